// File: doc/BRIEF.md
# Thirty-Two Line Interrupt Collector

The block gathers 32 asynchronous interrupt request lines and reduces them to two processor request outputs: a normal request and a fast request. Each line first passes through a two-stage synchroniser. Software then sets, for each line on its own, several options:

- whether the line is edge or level sensitive;
- which polarity counts as active;
- whether the line is enabled;
- which of the two outputs it reaches.

A level-sensitive line shows its active state directly in the raw status word. An edge-sensitive line records its event in a sticky flag. Software acknowledges that flag by writing a one to the matching bit of the raw status word.

Software reaches the block through a plain register port. Writes are single-cycle, with a write strobe, a byte address and 32 data bits. Reads are combinational from the address. Source n always sits in bit n of every word. Word offsets are:

| Offset | Word |
|--------|------|
| 0x00 | enable |
| 0x04 | raw status |
| 0x08 | enabled status |
| 0x0C | polarity |
| 0x10 | trigger type |
| 0x14 | fast-output select |

A handler reads the enabled status word and services the set bits from bit 0 upward.

Top module: `intc32_top`

## Requirements
- R1: After reset the enable (0x00), polarity (0x0C), trigger type (0x10) and fast-select (0x14) words read zero, and both outputs are low. A write to any of these four words is read back unchanged from the next cycle on.
- R2: A change on a source input reaches the raw status word two clock edges after the input is sampled. The change comes through a two-flop synchroniser.
- R3: Polarity bit 1 makes a source active when high, or on a rising edge. Polarity bit 0 makes it active when low, or on a falling edge. With all-zero configuration and all inputs low, the raw word therefore reads 0xFFFFFFFF.
- R4: With trigger type bit 0 (level), the raw bit equals the polarity-corrected synchronised input. Writing a 1 to that bit of the raw word (0x04) has no effect.
- R5: With trigger type bit 1 (edge), a transition into the active state sets the raw bit one edge after it appears at the synchroniser output. The bit stays set after the input returns to its inactive state.
- R6: Writing a 1 to bit n of the raw word (0x04) clears a latched edge event of source n. Bits written as 0 are left unchanged.
- R7: If a new active edge is detected in the same cycle that an acknowledge write clears the same bit, the bit remains set.
- R8: The enabled status word (0x08) reads the raw word ANDed with the enable word. Writes to 0x08 change nothing.
- R9: The normal request output is high one cycle after any enabled pending source has fast-select 0. The fast request output is high one cycle after any enabled pending source has fast-select 1.
- R10: Changing the polarity of an edge-typed source whose input is steady does not record an edge event.
- R11: Addresses 0x18 and 0x1C read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte address of the word (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at bus_addr |
| src_in | input | 32 | Asynchronous interrupt source lines |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The collision of interest is between an edge being latched and a write-one acknowledge landing on the same bit in the same cycle. The bench re-arms an already latched edge source by dropping and then raising its input. It times the acknowledge write to arrive exactly two edges after the rising input is first sampled, which is the cycle the edge detector fires. A behavioural model with a sample-history queue predicts the raw, status and output values on every clock. The bit must read as set afterwards, and the request output must stay high.

// File: rtl/intc32_pkg.sv
package intc32_pkg;

    // Word index (byte address bits 4:2) of each software-visible word.
    typedef enum logic [2:0] {
        WD_ENA  = 3'd0,
        WD_RAW  = 3'd1,
        WD_STAT = 3'd2,
        WD_POL  = 3'd3,
        WD_TYP  = 3'd4,
        WD_FSEL = 3'd5
    } word_e;

    localparam int unsigned WORD_IDX_W = 3;

endpackage

// File: rtl/intc32_sync.sv
module intc32_sync #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);

    typedef struct packed {
        logic [N-1:0] stage1;
        logic [N-1:0] stage2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stage1 = async_i;
        s_d.stage2 = s_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.stage2;

endmodule

// File: rtl/intc32_trig.sv
module intc32_trig #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] typ_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] evt_o
);

    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] latch;
    } trig_t;

    trig_t t_d, t_q;
    logic [N-1:0] lvl_now;
    logic [N-1:0] lvl_old;

    // Polarity applied to both current and previous samples, so a polarity
    // change on a steady line never looks like a transition.
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign lvl_now[i] = sync_i[i] ~^ pol_i[i];
        assign lvl_old[i] = t_q.prev[i] ~^ pol_i[i];
        assign evt_o[i]   = lvl_now[i] & ~lvl_old[i];
        assign raw_o[i]   = typ_i[i] ? t_q.latch[i] : lvl_now[i];
    end

    always_comb begin
        t_d       = t_q;
        t_d.prev  = sync_i;
        // New event wins over an acknowledge in the same cycle.
        t_d.latch = typ_i & (evt_o | (t_q.latch & ~ack_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

endmodule

// File: rtl/intc32_regs.sv
module intc32_regs
    import intc32_pkg::*;
#(
    parameter int unsigned N  = 32,
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [N-1:0]  bus_wdata,
    input  logic [N-1:0]  raw_i,
    input  logic [N-1:0]  stat_i,
    output logic [N-1:0]  bus_rdata,
    output logic [N-1:0]  ena_o,
    output logic [N-1:0]  pol_o,
    output logic [N-1:0]  typ_o,
    output logic [N-1:0]  fsel_o,
    output logic [N-1:0]  ack_o
);

    localparam int unsigned SEL_W = AW - 2;

    typedef struct packed {
        logic [N-1:0] ena;
        logic [N-1:0] pol;
        logic [N-1:0] typ;
        logic [N-1:0] fsel;
    } cfg_t;

    cfg_t c_d, c_q;
    logic [SEL_W-1:0] sel;

    assign sel = bus_addr[AW-1:2];

    always_comb begin
        c_d   = c_q;
        ack_o = '0;
        if (bus_we) begin
            case (sel)
                SEL_W'(WD_ENA):  c_d.ena  = bus_wdata;
                SEL_W'(WD_RAW):  ack_o    = bus_wdata;
                SEL_W'(WD_POL):  c_d.pol  = bus_wdata;
                SEL_W'(WD_TYP):  c_d.typ  = bus_wdata;
                SEL_W'(WD_FSEL): c_d.fsel = bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_W'(WD_ENA):  bus_rdata = c_q.ena;
            SEL_W'(WD_RAW):  bus_rdata = raw_i;
            SEL_W'(WD_STAT): bus_rdata = stat_i;
            SEL_W'(WD_POL):  bus_rdata = c_q.pol;
            SEL_W'(WD_TYP):  bus_rdata = c_q.typ;
            SEL_W'(WD_FSEL): bus_rdata = c_q.fsel;
            default:         bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ena_o  = c_q.ena;
    assign pol_o  = c_q.pol;
    assign typ_o  = c_q.typ;
    assign fsel_o = c_q.fsel;

endmodule

// File: rtl/intc32_route.sv
module intc32_route #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] stat_i,
    input  logic [N-1:0] fsel_i,
    output logic         irq_o,
    output logic         fiq_o
);

    typedef struct packed {
        logic irq;
        logic fiq;
    } req_t;

    req_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.irq = |(stat_i & ~fsel_i);
        r_d.fiq = |(stat_i & fsel_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq_o = r_q.irq;
    assign fiq_o = r_q.fiq;

endmodule

// File: rtl/intc32_top.sv
module intc32_top #(
    parameter int unsigned N  = 32,
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [N-1:0]  bus_wdata,
    output logic [N-1:0]  bus_rdata,
    input  logic [N-1:0]  src_in,
    output logic          irq_o,
    output logic          fiq_o
);

    logic [N-1:0] sync_w;
    logic [N-1:0] ena_w;
    logic [N-1:0] pol_w;
    logic [N-1:0] typ_w;
    logic [N-1:0] fsel_w;
    logic [N-1:0] ack_w;
    logic [N-1:0] raw_w;
    logic [N-1:0] evt_w;
    logic [N-1:0] stat_w;

    intc32_sync #(.N(N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_in),
        .sync_o  (sync_w)
    );

    intc32_trig #(.N(N)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_w),
        .pol_i  (pol_w),
        .typ_i  (typ_w),
        .ack_i  (ack_w),
        .raw_o  (raw_w),
        .evt_o  (evt_w)
    );

    assign stat_w = raw_w & ena_w;

    intc32_regs #(.N(N), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .raw_i     (raw_w),
        .stat_i    (stat_w),
        .bus_rdata (bus_rdata),
        .ena_o     (ena_w),
        .pol_o     (pol_w),
        .typ_o     (typ_w),
        .fsel_o    (fsel_w),
        .ack_o     (ack_w)
    );

    intc32_route #(.N(N)) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (stat_w),
        .fsel_i (fsel_w),
        .irq_o  (irq_o),
        .fiq_o  (fiq_o)
    );

endmodule

// File: rtl/intc32_chk.sv
module intc32_chk #(
    parameter int unsigned N  = 32,
    parameter int unsigned AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [N-1:0]  bus_wdata,
    input logic          irq_o,
    input logic          fiq_o,
    input logic [N-1:0]  ena_w,
    input logic [N-1:0]  typ_w,
    input logic [N-1:0]  raw_w,
    input logic [N-1:0]  stat_w,
    input logic [N-1:0]  evt_w,
    input logic [N-1:0]  fsel_w
);

    localparam int unsigned SEL_W = AW - 2;

    logic [SEL_W-1:0] sel;
    assign sel = bus_addr[AW-1:2];

    AST_IRQ_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_o == $past(|(stat_w & ~fsel_w)))); // R9

    AST_FIQ_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fiq_o == $past(|(stat_w & fsel_w)))); // R9

    AST_ENA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_W'(0)) |=> (ena_w == $past(bus_wdata))); // R1

    AST_STAT_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_W'(2)) |=> ($stable(ena_w) && $stable(typ_w) && $stable(fsel_w))); // R8

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_W'(1)) |=> (($past(bus_wdata & ~evt_w) & typ_w & raw_w) == '0)); // R6

    AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(evt_w & typ_w) & typ_w & ~raw_w) == '0)); // R7

endmodule

bind intc32_top intc32_chk #(.N(N), .AW(AW)) u_chk (.*);

// File: tb/intc32_top_tb.sv
module intc32_top_tb;

    localparam int unsigned N  = 32;
    localparam int unsigned AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  src_in = '0;
    logic [N-1:0]  bus_rdata;
    logic          irq_o;
    logic          fiq_o;

    always #10 clk = ~clk;

    intc32_top #(.N(N), .AW(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_in    (src_in),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    // Behavioural reference: configuration words, sticky edge flags,
    // registered outputs and a history queue of sampled inputs.
    logic [31:0] m_ena, m_pol, m_typ, m_fsel, m_flag;
    logic        m_irq, m_fiq;
    logic [31:0] hist[$];

    int n_chk = 0;
    int n_bad = 0;
    bit checking = 0;
    bit finished = 0;
    string cur_req = "R1";
    logic [31:0] src_v = '0;

    function automatic logic [31:0] m_raw();
        logic [31:0] act;
        act = ~(hist[1] ^ m_pol);
        return (m_typ & m_flag) | (~m_typ & act);
    endfunction

    function automatic logic [31:0] m_read(logic [4:0] a);
        case (a[4:2])
            3'd0: return m_ena;
            3'd1: return m_raw();
            3'd2: return m_raw() & m_ena;
            3'd3: return m_pol;
            3'd4: return m_typ;
            3'd5: return m_fsel;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] cur_act, old_act, rise, stat, ackv;
        if (!rst_n) begin
            m_ena = '0; m_pol = '0; m_typ = '0; m_fsel = '0; m_flag = '0;
            m_irq = 1'b0; m_fiq = 1'b0;
            hist = {32'h0, 32'h0, 32'h0};
        end else begin
            cur_act = ~(hist[1] ^ m_pol);
            old_act = ~(hist[2] ^ m_pol);
            rise    = cur_act & ~old_act;
            stat    = m_raw() & m_ena;
            m_irq   = |(stat & ~m_fsel);
            m_fiq   = |(stat & m_fsel);
            ackv    = (bus_we && bus_addr[4:2] == 3'd1) ? bus_wdata : 32'h0;
            m_flag  = m_typ & (rise | (m_flag & ~ackv));
            if (bus_we) begin
                case (bus_addr[4:2])
                    3'd0: m_ena  = bus_wdata;
                    3'd3: m_pol  = bus_wdata;
                    3'd4: m_typ  = bus_wdata;
                    3'd5: m_fsel = bus_wdata;
                    default: ;
                endcase
            end
            hist.push_front(src_in);
            void'(hist.pop_back());
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(logic we, logic [4:0] a, logic [31:0] wd, logic [31:0] s);
        @(negedge clk);
        if (checking) begin
            chk({cur_req, " rdata"}, bus_rdata, m_read(bus_addr));
            chk({cur_req, " irq"}, {31'b0, irq_o}, {31'b0, m_irq});
            chk({cur_req, " fiq"}, {31'b0, fiq_o}, {31'b0, m_fiq});
        end
        bus_we = we; bus_addr = a; bus_wdata = wd; src_in = s;
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        step(1'b1, a, d, src_v);
    endtask

    task automatic rd(logic [4:0] a);
        step(1'b0, a, 32'h0, src_v);
    endtask

    task automatic setsrc(logic [31:0] s);
        src_v = s;
        step(1'b0, 5'h04, 32'h0, src_v);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) rd(5'h04);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checking = 1;

        // R1: reset values; R3: all-zero config gives all-ones raw
        cur_req = "R1";
        rd(5'h00); rd(5'h0C); rd(5'h10); rd(5'h14);
        cur_req = "R3";
        rd(5'h04); rd(5'h08);
        cur_req = "R1";
        wr(5'h00, 32'hA5A5_0000); rd(5'h00); wr(5'h00, 32'h0); rd(5'h00);

        // R3: bits 0..5 active high
        cur_req = "R3";
        wr(5'h0C, 32'h0000_003F); idle(2);

        // R2: synchroniser latency on a level source
        cur_req = "R2";
        setsrc(32'h0000_0048); rd(5'h04); rd(5'h04); rd(5'h04);
        setsrc(32'h0000_0040); rd(5'h04); rd(5'h04); rd(5'h04);
        setsrc(32'h0000_0048); idle(3);

        // R5: bit 5 rising edge, bit 6 falling edge
        cur_req = "R5";
        wr(5'h10, 32'h0000_0060); idle(2);
        setsrc(32'h0000_0068); idle(3);
        setsrc(32'h0000_0048); idle(3);
        setsrc(32'h0000_0008); idle(3);

        // R6: acknowledge bit 5, zero write leaves bit 6
        cur_req = "R6";
        wr(5'h04, 32'h0000_0020); rd(5'h04);
        wr(5'h04, 32'h0000_0000); rd(5'h04);

        // R4: level bit 3 cannot be cleared
        cur_req = "R4";
        wr(5'h04, 32'h0000_0008); rd(5'h04); rd(5'h04);

        // R8: enabled status, write to it ignored
        cur_req = "R8";
        wr(5'h00, 32'h0000_0068); rd(5'h08);
        wr(5'h08, 32'hFFFF_FFFF); rd(5'h00); rd(5'h08);

        // R7: new edge coincides with acknowledge
        cur_req = "R7";
        setsrc(32'h0000_0028); idle(3);
        setsrc(32'h0000_0008); idle(3);
        setsrc(32'h0000_0028); rd(5'h08);
        wr(5'h04, 32'h0000_0020);
        rd(5'h04); rd(5'h04); rd(5'h08);

        // R9: steering to the fast output
        cur_req = "R9";
        wr(5'h14, 32'h0000_0020); idle(3);
        wr(5'h04, 32'h0000_0060); idle(2);
        setsrc(32'h0000_0000); idle(4);
        setsrc(32'h0000_0020); idle(4);

        // R10: polarity flip on a steady edge source
        cur_req = "R10";
        wr(5'h04, 32'h0000_0020); idle(2);
        wr(5'h0C, 32'h0000_001F); idle(4);
        wr(5'h0C, 32'h0000_003F); idle(4);

        // R11: unmapped words
        cur_req = "R11";
        rd(5'h18); rd(5'h1C);
        wr(5'h18, 32'hFFFF_FFFF); wr(5'h1C, 32'hFFFF_FFFF);
        rd(5'h00); rd(5'h0C); rd(5'h10); rd(5'h14); rd(5'h18);

        // R9: mixed traffic
        cur_req = "R9";
        for (int i = 0; i < 400; i++) begin
            logic [4:0] a;
            a = 5'($urandom_range(0, 7) * 4);
            src_v = (i % 8 == 0) ? $urandom() : src_v;
            step(($urandom_range(0, 3) == 0), a, $urandom(), src_v);
        end
        idle(4);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule